// File: doc/BRIEF.md
# Stream Header Alignment Padder

This block sits between a 32-bit packet stream and the logic that consumes it, and moves each frame between its packed form and a form shifted by two byte lanes. In the shifted form every frame starts with two zero bytes. With a 14-byte link header, the network-layer header behind it then begins on a 32-bit word boundary, so software can read addresses with aligned word loads.

The block has two independent paths. The receive path inserts the two-byte zero prefix and the transmit path removes it. Each path has its own enable input, which is taken when a frame's first word is presented. A path that is not enabled passes its stream through combinationally, with no added cycle. Both paths use a ready/valid handshake. They carry start-of-packet and end-of-packet markers, and a 2-bit empty count that gives the number of unused low byte lanes on the last word (0 to 3).

Inside a word the earliest byte sits in bits 31..24, then 23..16, then 15..8, then 7..0. A shifted frame carries the two lanes a word cannot hold into the next word. When the tail does not fit, the block appends one more word.

Top module: `hdr_align_shift`

## Requirements
- R1: Byte order within a word is bits 31..24 first, then 23..16, 15..8, 7..0. With the receive enable set, the first output word of a frame is {8'h00, 8'h00, byte0, byte1} and carries start-of-packet.
- R2: With the receive enable set, each later output word holds the next four frame bytes in order (the second word is byte2..byte5), so the stream is delayed by exactly two lanes.
- R3: On the receive path the output empty count is (input empty + 2) mod 4. When the input's last word has empty 0 or 1, one extra word follows it. That extra word holds the two leftover bytes in bits 31..16 and zeros in bits 15..0, and carries end-of-packet.
- R4: With the transmit enable set, bits 31..16 of a frame's first input word are ignored. The output is the frame bytes packed from byte0 in bits 31..24, merged across input word boundaries.
- R5: On the transmit path the output empty count is (input empty + 2) mod 4. An input last word with empty 0 or 1 produces one extra output word. A frame that fits in one input word produces exactly one output word, which carries both markers.
- R6: With the transmit enable set, the first input word of a frame is accepted while no output beat is presented, whatever the output ready is. The next output beat carries start-of-packet.
- R7: With a path's enable clear at start of packet, that frame's words appear at the output in the same cycle, unchanged: valid, data, markers and empty. Input ready equals output ready.
- R8: The receive and transmit enables act independently, and both paths can carry frames at the same time in different modes.
- R9: An enable is sampled only on the accepted first word of a frame. A change during a frame has no effect until the next start of packet.
- R10: Under output backpressure no beat is lost or duplicated. While an extra tail word waits, input ready is low and that word is held at the output.
- R11: After reset no extra word is pending. With idle inputs, both output valids are low and each input ready equals its output ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_shift_en | input | 1 | Receive-path prefix insertion enable, sampled at start of packet |
| rxi_valid | input | 1 | Receive input word valid |
| rxi_ready | output | 1 | Receive input ready |
| rxi_data | input | 32 | Receive input word |
| rxi_sop | input | 1 | Receive input start of packet |
| rxi_eop | input | 1 | Receive input end of packet |
| rxi_empty | input | 2 | Receive input unused low lanes on last word |
| rxo_valid | output | 1 | Receive output word valid |
| rxo_ready | input | 1 | Receive output ready |
| rxo_data | output | 32 | Receive output word |
| rxo_sop | output | 1 | Receive output start of packet |
| rxo_eop | output | 1 | Receive output end of packet |
| rxo_empty | output | 2 | Receive output unused low lanes on last word |
| tx_shift_en | input | 1 | Transmit-path prefix removal enable, sampled at start of packet |
| txi_valid | input | 1 | Transmit input word valid |
| txi_ready | output | 1 | Transmit input ready |
| txi_data | input | 32 | Transmit input word |
| txi_sop | input | 1 | Transmit input start of packet |
| txi_eop | input | 1 | Transmit input end of packet |
| txi_empty | input | 2 | Transmit input unused low lanes on last word |
| txo_valid | output | 1 | Transmit output word valid |
| txo_ready | input | 1 | Transmit output ready |
| txo_data | output | 32 | Transmit output word |
| txo_sop | output | 1 | Transmit output start of packet |
| txo_eop | output | 1 | Transmit output end of packet |
| txo_empty | output | 2 | Transmit output unused low lanes on last word |

## Verification
The assertions check the following on every cycle:
- An accepted tail word with empty 0 or 1 is followed by an extra end-of-packet word with a zero low half while input ready stays low.
- A first word that inserts the prefix has zero upper lanes.
- An absorbed first word on the transmit path presents no beat and raises start-of-packet on the next one.
- A held tail word stays stable.
- An enable register changes only on an accepted start of packet.

Only the bench's scenarios can show that whole frames come out byte-exact with the right empty counts. That covers every length from one byte upward, the ignored lanes, the same-cycle bypass, enable flips in mid-frame, and both paths running concurrently in different modes under random backpressure.

// File: rtl/hdr_align_shift.sv
module hdr_align_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_shift_en,
  input  logic        rxi_valid,
  output logic        rxi_ready,
  input  logic [31:0] rxi_data,
  input  logic        rxi_sop,
  input  logic        rxi_eop,
  input  logic [1:0]  rxi_empty,
  output logic        rxo_valid,
  input  logic        rxo_ready,
  output logic [31:0] rxo_data,
  output logic        rxo_sop,
  output logic        rxo_eop,
  output logic [1:0]  rxo_empty,
  input  logic        tx_shift_en,
  input  logic        txi_valid,
  output logic        txi_ready,
  input  logic [31:0] txi_data,
  input  logic        txi_sop,
  input  logic        txi_eop,
  input  logic [1:0]  txi_empty,
  output logic        txo_valid,
  input  logic        txo_ready,
  output logic [31:0] txo_data,
  output logic        txo_sop,
  output logic        txo_eop,
  output logic [1:0]  txo_empty
);
  localparam int HW = 16;
  localparam logic [1:0] SHIFT = 2'd2;

  // receive path: insert two zero lanes
  logic          rx_en_q, rx_pend, rx_mode, rx_acc, rx_tail;
  logic [HW-1:0] rx_carry;
  logic [1:0]    rx_pend_empty;

  assign rx_mode   = (rxi_valid && rxi_sop) ? rx_shift_en : rx_en_q;
  assign rxi_ready = rxo_ready && !rx_pend;
  assign rx_acc    = rxi_valid && rxi_ready;
  assign rx_tail   = rxi_eop && !rxi_empty[1];

  always_comb begin
    if (rx_pend) begin
      rxo_valid = 1'b1;
      rxo_data  = {rx_carry, {HW{1'b0}}};
      rxo_sop   = 1'b0;
      rxo_eop   = 1'b1;
      rxo_empty = rx_pend_empty;
    end else if (rx_mode) begin
      rxo_valid = rxi_valid;
      rxo_data  = {(rxi_sop ? {HW{1'b0}} : rx_carry), rxi_data[31:HW]};
      rxo_sop   = rxi_sop;
      rxo_eop   = rxi_eop && rxi_empty[1];
      rxo_empty = rxo_eop ? rxi_empty + SHIFT : 2'd0;
    end else begin
      rxo_valid = rxi_valid;
      rxo_data  = rxi_data;
      rxo_sop   = rxi_sop;
      rxo_eop   = rxi_eop;
      rxo_empty = rxi_empty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q       <= 1'b0;
      rx_pend       <= 1'b0;
      rx_carry      <= '0;
      rx_pend_empty <= 2'd0;
    end else begin
      if (rx_pend && rxo_ready) rx_pend <= 1'b0;
      if (rx_acc) begin
        if (rxi_sop) rx_en_q <= rx_shift_en;
        if (rx_mode) begin
          rx_carry <= rxi_data[HW-1:0];
          if (rx_tail) begin
            rx_pend       <= 1'b1;
            rx_pend_empty <= rxi_empty + SHIFT;
          end
        end
      end
    end
  end

  // transmit path: remove two leading lanes
  logic          tx_en_q, tx_pend, tx_mode, tx_acc, tx_tail, tx_absorb, tx_first;
  logic [HW-1:0] tx_carry;
  logic [1:0]    tx_pend_empty;

  assign tx_mode   = (txi_valid && txi_sop) ? tx_shift_en : tx_en_q;
  assign tx_absorb = tx_mode && txi_valid && txi_sop;
  assign txi_ready = !tx_pend && (txo_ready || tx_absorb);
  assign tx_acc    = txi_valid && txi_ready;
  assign tx_tail   = txi_eop && !txi_empty[1];

  always_comb begin
    if (tx_pend) begin
      txo_valid = 1'b1;
      txo_data  = {tx_carry, {HW{1'b0}}};
      txo_sop   = tx_first;
      txo_eop   = 1'b1;
      txo_empty = tx_pend_empty;
    end else if (tx_mode) begin
      txo_valid = txi_valid && !txi_sop;
      txo_data  = {tx_carry, txi_data[31:HW]};
      txo_sop   = tx_first;
      txo_eop   = txi_eop && txi_empty[1];
      txo_empty = txo_eop ? txi_empty + SHIFT : 2'd0;
    end else begin
      txo_valid = txi_valid;
      txo_data  = txi_data;
      txo_sop   = txi_sop;
      txo_eop   = txi_eop;
      txo_empty = txi_empty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q       <= 1'b0;
      tx_pend       <= 1'b0;
      tx_first      <= 1'b0;
      tx_carry      <= '0;
      tx_pend_empty <= 2'd0;
    end else begin
      if (tx_pend && txo_ready) begin
        tx_pend  <= 1'b0;
        tx_first <= 1'b0;
      end
      if (tx_acc) begin
        if (txi_sop) tx_en_q <= tx_shift_en;
        if (tx_mode) begin
          tx_carry <= txi_data[HW-1:0];
          tx_first <= txi_sop;
          if (tx_tail) begin
            tx_pend       <= 1'b1;
            tx_pend_empty <= txi_empty + SHIFT;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdr_align_shift_chk.sv
module hdr_align_shift_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_mode,
  input logic        rx_acc,
  input logic        rx_pend,
  input logic        rx_en_q,
  input logic        rxi_ready,
  input logic        rxi_sop,
  input logic        rxi_eop,
  input logic [1:0]  rxi_empty,
  input logic        rxo_valid,
  input logic        rxo_ready,
  input logic [31:0] rxo_data,
  input logic        rxo_sop,
  input logic        rxo_eop,
  input logic [1:0]  rxo_empty,
  input logic        tx_mode,
  input logic        tx_acc,
  input logic        tx_pend,
  input logic        tx_en_q,
  input logic        txi_valid,
  input logic        txi_sop,
  input logic        txi_eop,
  input logic [1:0]  txi_empty,
  input logic        txo_valid,
  input logic [31:0] txo_data,
  input logic        txo_sop,
  input logic        txo_eop,
  input logic [1:0]  txo_empty
);
  a_r1_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rxo_valid && rxo_sop && rx_mode && !rx_pend) |-> (rxo_data[31:16] == 16'h0));

  a_r3_tail_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_acc && rx_mode && rxi_eop && !rxi_empty[1]) |=>
      (rxo_valid && rxo_eop && rxo_empty[1] && rxo_data[15:0] == 16'h0 && !rxi_ready));

  a_r5_tail_word: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && tx_mode && txi_eop && !txi_empty[1]) |=>
      (txo_valid && txo_eop && txo_empty[1] && txo_data[15:0] == 16'h0));

  a_r6_absorb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && txi_valid && txi_sop && !tx_pend) |-> !txo_valid);

  a_r6_sop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && tx_mode && txi_sop) |=> txo_sop);

  a_r9_rx_en_at_sop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_en_q) |-> $past(rx_acc && rxi_sop));

  a_r9_tx_en_at_sop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_en_q) |-> $past(tx_acc && txi_sop));

  a_r10_tail_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && !rxo_ready) |=> (rxo_valid && rxo_eop && $stable(rxo_data) && $stable(rxo_empty)));

  a_r7_no_tail_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_pend) || $rose(tx_pend)) |-> ($past(rx_mode) || $past(tx_mode)));
endmodule

bind hdr_align_shift hdr_align_shift_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .rx_mode(rx_mode), .rx_acc(rx_acc), .rx_pend(rx_pend), .rx_en_q(rx_en_q),
  .rxi_ready(rxi_ready), .rxi_sop(rxi_sop), .rxi_eop(rxi_eop), .rxi_empty(rxi_empty),
  .rxo_valid(rxo_valid), .rxo_ready(rxo_ready), .rxo_data(rxo_data), .rxo_sop(rxo_sop),
  .rxo_eop(rxo_eop), .rxo_empty(rxo_empty),
  .tx_mode(tx_mode), .tx_acc(tx_acc), .tx_pend(tx_pend), .tx_en_q(tx_en_q),
  .txi_valid(txi_valid), .txi_sop(txi_sop), .txi_eop(txi_eop), .txi_empty(txi_empty),
  .txo_valid(txo_valid), .txo_data(txo_data), .txo_sop(txo_sop),
  .txo_eop(txo_eop), .txo_empty(txo_empty)
);

// File: tb/hdr_align_shift_tb_top.sv
module hdr_align_shift_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        en   [2];
  logic        iv   [2];
  logic        ir   [2];
  logic [31:0] id   [2];
  logic        isop [2];
  logic        ieop [2];
  logic [1:0]  ie   [2];
  logic        ov   [2];
  logic        ordy [2];
  logic [31:0] od   [2];
  logic        osop [2];
  logic        oeop [2];
  logic [1:0]  oe   [2];

  hdr_align_shift dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_shift_en(en[0]), .rxi_valid(iv[0]), .rxi_ready(ir[0]), .rxi_data(id[0]),
    .rxi_sop(isop[0]), .rxi_eop(ieop[0]), .rxi_empty(ie[0]),
    .rxo_valid(ov[0]), .rxo_ready(ordy[0]), .rxo_data(od[0]),
    .rxo_sop(osop[0]), .rxo_eop(oeop[0]), .rxo_empty(oe[0]),
    .tx_shift_en(en[1]), .txi_valid(iv[1]), .txi_ready(ir[1]), .txi_data(id[1]),
    .txi_sop(isop[1]), .txi_eop(ieop[1]), .txi_empty(ie[1]),
    .txo_valid(ov[1]), .txo_ready(ordy[1]), .txo_data(od[1]),
    .txo_sop(osop[1]), .txo_eop(oeop[1]), .txo_empty(oe[1])
  );

  typedef struct {
    logic [31:0] d;
    logic        s;
    logic        e;
    logic [1:0]  m;
    int          tag;
  } beat_t;

  beat_t q0[$];
  beat_t q1[$];
  int vec = 0;
  int miss = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  function automatic string rtag(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic note(int t, bit ok, string what, logic [35:0] act, logic [35:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s actual=%h expected=%h", rtag(t), what, act, exp);
    end
  endtask

  function automatic void pack(input byte unsigned b[$], output beat_t w[$]);
    int n = b.size();
    int nw = (n + 3) / 4;
    w = {};
    for (int k = 0; k < nw; k++) begin
      beat_t x;
      x.d = '0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < n) x.d[31 - 8 * j -: 8] = b[4 * k + j];
      x.s = (k == 0);
      x.e = (k == nw - 1);
      x.m = x.e ? 2'(4 - (n - 4 * k)) : 2'd0;
      x.tag = 0;
      w.push_back(x);
    end
  endfunction

  task automatic send(int d, bit en_v, int len, int seed, bit toggle, int tag);
    byte unsigned pay[$], inb[$], outb[$];
    beat_t iw[$], ow[$];
    for (int i = 0; i < len; i++) pay.push_back(8'(((seed * 53) + i * 29) % 251 + 1));
    if (en_v && d == 0) begin
      outb.push_back(8'h00); outb.push_back(8'h00);
      foreach (pay[i]) outb.push_back(pay[i]);
      inb = pay;
    end else if (en_v) begin
      inb.push_back(8'hA5); inb.push_back(8'h5A);
      foreach (pay[i]) inb.push_back(pay[i]);
      outb = pay;
    end else begin
      inb = pay;
      outb = pay;
    end
    pack(inb, iw);
    pack(outb, ow);
    foreach (ow[k]) begin
      if (tag != 0) ow[k].tag = tag;
      else if (!en_v) ow[k].tag = 7;
      else if (d == 0) ow[k].tag = (k == 0) ? 1 : (ow[k].e ? 3 : 2);
      else ow[k].tag = (k == 0) ? 6 : (ow[k].e ? 5 : 4);
      if (d == 0) q0.push_back(ow[k]); else q1.push_back(ow[k]);
    end
    foreach (iw[k]) begin
      @(negedge clk);
      if (k == 0) en[d] = en_v;
      else if (toggle) en[d] = !en_v;
      iv[d] = 1'b1; id[d] = iw[k].d; isop[d] = iw[k].s; ieop[d] = iw[k].e; ie[d] = iw[k].m;
      #2;
      while (!ir[d]) begin
        @(negedge clk);
        #2;
      end
      if (!en_v)
        note(tag != 0 ? tag : 7, ov[d] === 1'b1 && od[d] === iw[k].d && ir[d] === ordy[d],
             "bypass word not presented in the same cycle", {3'b0, ov[d], od[d]}, {4'b0001, iw[k].d});
    end
    @(negedge clk);
    iv[d] = 1'b0; isop[d] = 1'b0; ieop[d] = 1'b0;
    if (en_v && iw[iw.size() - 1].m < 2) begin
      #2;
      note(10, ir[d] === 1'b0 && ov[d] === 1'b1 && oeop[d] === 1'b1,
           "input not blocked while tail word pending", {33'b0, ir[d], ov[d], oeop[d]}, 36'b011);
    end
  endtask

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) ordy[d] = bp_on ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        if (ov[d] && ordy[d]) begin
          beat_t x;
          bit has;
          if (d == 0) begin has = q0.size() > 0; if (has) x = q0.pop_front(); end
          else begin has = q1.size() > 0; if (has) x = q1.pop_front(); end
          if (!has)
            note(10, 1'b0, "unexpected output beat", {osop[d], oeop[d], oe[d], od[d]}, 36'b0);
          else
            note(x.tag, od[d] === x.d && osop[d] === x.s && oeop[d] === x.e && (!x.e || oe[d] === x.m),
                 d == 0 ? "receive beat mismatch" : "transmit beat mismatch",
                 {osop[d], oeop[d], oe[d], od[d]}, {x.s, x.e, x.m, x.d});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    vec++;
    miss++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      en[d] = 1'b0; iv[d] = 1'b0; id[d] = '0; isop[d] = 1'b0; ieop[d] = 1'b0; ie[d] = 2'd0;
    end
    repeat (3) @(negedge clk);
    #2;
    note(11, ov[0] === 1'b0 && ov[1] === 1'b0 && ir[0] === ordy[0] && ir[1] === ordy[1],
         "state during reset", {32'b0, ov[0], ov[1], ir[0], ir[1]}, 36'b0011);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    note(11, ov[0] === 1'b0 && ov[1] === 1'b0 && ir[0] === 1'b1 && ir[1] === 1'b1,
         "idle state after reset", {32'b0, ov[0], ov[1], ir[0], ir[1]}, 36'b0011);

    for (int L = 1; L <= 9; L++) send(0, 1'b1, L, L, 1'b0, 0);
    for (int L = 1; L <= 9; L++) send(1, 1'b1, L, L + 20, 1'b0, 0);
    send(0, 1'b0, 1, 3, 1'b0, 0);
    send(0, 1'b0, 7, 4, 1'b0, 0);
    send(1, 1'b0, 5, 5, 1'b0, 0);
    send(1, 1'b0, 8, 6, 1'b0, 0);

    bp_on = 1'b1;
    for (int L = 1; L <= 9; L++) send(0, 1'b1, L, L + 40, 1'b0, 0);
    for (int L = 1; L <= 9; L++) send(1, 1'b1, L, L + 60, 1'b0, 0);
    send(0, 1'b1, 60, 7, 1'b0, 0);
    send(1, 1'b1, 61, 8, 1'b0, 0);

    send(0, 1'b1, 11, 9, 1'b1, 9);
    send(1, 1'b1, 10, 10, 1'b1, 9);
    send(0, 1'b0, 9, 11, 1'b1, 9);
    send(1, 1'b0, 6, 12, 1'b1, 9);

    fork
      send(0, 1'b1, 13, 13, 1'b0, 8);
      send(1, 1'b0, 13, 14, 1'b0, 8);
    join
    fork
      send(0, 1'b0, 14, 15, 1'b0, 8);
      send(1, 1'b1, 15, 16, 1'b0, 8);
    join

    for (int i = 0; i < 200 && (q0.size() != 0 || q1.size() != 0); i++) @(negedge clk);
    repeat (2) @(negedge clk);
    note(10, q0.size() == 0 && q1.size() == 0, "expected beats never delivered",
         36'(q0.size() + q1.size()), 36'd0);
    finish_run();
  end
endmodule